// File: doc/BRIEF.md
# SCL Rate Divider Configurator

This block turns a pair of rates, the functional clock and the wanted serial-clock rate, both in kHz, into a prescaler setting for a two-wire bus master. The setting has two parts. A coarse stage divides by 16 or by 512. A fine stage divides by 1 to 17. The block also produces the serial-clock rate that this setting actually gives and a data-line hold delay code with its glitch-filter enable. A run starts with a one-cycle strobe. Three divisions then run one after another on a single shared restoring divider, one quotient bit per cycle.

A setting is rejected when the rate it gives is faster than the target. A setting that is accepted is staged and goes live only at the next tick boundary. A free-running counter, using the live setting, produces a one-cycle tick every coarse times fine clocks. The bit engine of the bus master consumes this tick.

Top module: `scl_div_cfg`

## Requirements
- R1: A target rate of 0 is treated as 100 kHz in every computation, including the error comparison.
- R2: With ratio = floor(clk_khz / target), the coarse prescaler is 512 (coarse_sel = 1) when the ratio is above 256, and 16 (coarse_sel = 0) otherwise. A ratio of exactly 256 keeps 16.
- R3: The fine divisor is ceil(ratio / coarse), clamped to the range 1..17. The fine_field output carries the fine divisor minus one, so it never exceeds 16.
- R4: After a run, achieved_khz equals floor(clk_khz / (fine × coarse)). This holds whether the setting is accepted or rejected.
- R5: cfg_err is 1 after a run whose achieved rate is above the target, and 0 otherwise. A rejected run leaves coarse_sel, fine_field, sda_dly and filt_en unchanged.
- R6: With q = floor(achieved_khz × dly_ns / 10^9), sda_dly is 0 when dly_ns is 0 or q is 0, 1 for q in 1..5, 2 for q in 6..10, and 3 above 10. filt_en is 1 exactly when dly_ns is non-zero.
- R7: tick is a one-cycle pulse. Successive pulses are (fine_field + 1) × (coarse_sel ? 512 : 16) clocks apart for the live setting.
- R8: The live setting outputs change only in the cycle in which tick is high. An accepted setting goes live at the first tick that follows the end of its run.
- R9: busy is 1 from the clock after start until the run's results are final. A start strobe seen while busy is ignored, and achieved_khz holds steady while busy.
- R10: After reset, busy, cfg_err, achieved_khz, coarse_sel, fine_field, sda_dly and filt_en are all 0, and the tick period is 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe that begins a computation |
| clk_khz | input | KHZ_W | Functional clock rate in kHz |
| tgt_khz | input | KHZ_W | Wanted serial-clock rate in kHz (0 means 100) |
| dly_ns | input | NS_W | Requested data-line hold delay in ns |
| busy | output | 1 | Computation in progress |
| cfg_err | output | 1 | Last run gave a rate above the target |
| achieved_khz | output | KHZ_W | Rate produced by the last computed setting |
| coarse_sel | output | 1 | Live coarse prescaler: 1 = 512, 0 = 16 |
| fine_field | output | 5 | Live fine divisor minus one |
| sda_dly | output | 2 | Live data-line delay code |
| filt_en | output | 1 | Live glitch-filter enable |
| tick | output | 1 | Serial-clock enable pulse |

## Verification
The checker watches several properties on every cycle:
- tick stays a single-cycle pulse.
- The live setting moves only together with a tick.
- fine_field stays within its clamp.
- A non-zero delay code never appears without the filter.
- The reported rate is frozen while a run is in flight.

The arithmetic results are shown only by the bench's sweep, which compares them with values computed from the formulas. These are the ratio split at 256, the round-up and the clamp at 17, the rejection of fast settings, the default target and the delay-code bands. The bench also shows the real spacing between ticks and that a start strobe sent mid-run is dropped.

// File: rtl/scl_cfg_pkg.sv
package scl_cfg_pkg;
  localparam int unsigned FINE_W      = 5;
  localparam int unsigned SDA_W       = 2;
  localparam int unsigned FINE_MAX    = 17;
  localparam int unsigned LO_SH       = 4;    // coarse 16
  localparam int unsigned HI_SH       = 9;    // coarse 512
  localparam int unsigned RATIO_SPLIT = 256;
  localparam int unsigned DEF_TGT     = 100;
  localparam int unsigned NS_SCALE    = 1000000000;
  localparam int unsigned SDA_BAND    = 5;
  localparam int unsigned SDA_MAX     = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RATIO,
    ST_RATE,
    ST_SDA
  } calc_st_t;
endpackage

// File: rtl/scl_iter_div.sv
module scl_iter_div #(
  parameter int unsigned W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, q_q, d_q;
  logic [CW-1:0] left_q;
  logic          run_q;
  logic [W:0]    shifted;
  logic [W-1:0]  rem_nx, q_nx;

  always_comb begin
    shifted = {rem_q, q_q[W-1]};
    if (shifted >= {1'b0, d_q}) begin
      rem_nx = W'(shifted - {1'b0, d_q});
      q_nx   = {q_q[W-2:0], 1'b1};
    end else begin
      rem_nx = shifted[W-1:0];
      q_nx   = {q_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      q_q    <= '0;
      d_q    <= '0;
      left_q <= '0;
      run_q  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !run_q) begin
        rem_q  <= '0;
        q_q    <= num;
        d_q    <= den;
        left_q <= CW'(W);
        run_q  <= 1'b1;
      end else if (run_q) begin
        rem_q  <= rem_nx;
        q_q    <= q_nx;
        left_q <= left_q - 1'b1;
        if (left_q == CW'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  assign quo = q_q;
endmodule

// File: rtl/scl_cfg_calc.sv
module scl_cfg_calc
  import scl_cfg_pkg::*;
#(
  parameter int unsigned KHZ_W = 20,
  parameter int unsigned NS_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [KHZ_W-1:0]  clk_khz,
  input  logic [KHZ_W-1:0]  tgt_khz,
  input  logic [NS_W-1:0]   dly_ns,
  output logic              busy,
  output logic              res_vld,
  output logic              res_err,
  output logic              res_big,
  output logic [FINE_W-1:0] res_fine,
  output logic [KHZ_W-1:0]  res_ach,
  output logic [SDA_W-1:0]  res_sda,
  output logic              res_filt
);
  localparam int unsigned DW = KHZ_W + NS_W;

  calc_st_t          st_q;
  logic [KHZ_W-1:0]  c_clk, c_tgt;
  logic [NS_W-1:0]   c_ns;
  logic              div_go;
  logic [DW-1:0]     div_num, div_den, quo;
  logic              div_done;
  logic              big_q;
  logic [FINE_W-1:0] fine_q;

  logic              big_c;
  logic [DW:0]       rnd_c;
  logic [FINE_W-1:0] fine_c;
  logic [DW-1:0]     den_c;
  logic [SDA_W-1:0]  sda_c;

  scl_iter_div #(.W(DW)) u_div (
    .clk  (clk),
    .rst  (rst),
    .go   (div_go),
    .num  (div_num),
    .den  (div_den),
    .done (div_done),
    .quo  (quo)
  );

  always_comb begin
    big_c = quo > DW'(RATIO_SPLIT);
    if (big_c) rnd_c = ({1'b0, quo} + (DW+1)'((1 << HI_SH) - 1)) >> HI_SH;
    else       rnd_c = ({1'b0, quo} + (DW+1)'((1 << LO_SH) - 1)) >> LO_SH;
    if (rnd_c == '0)                     fine_c = FINE_W'(1);
    else if (rnd_c > (DW+1)'(FINE_MAX))  fine_c = FINE_W'(FINE_MAX);
    else                                 fine_c = rnd_c[FINE_W-1:0];
    den_c = DW'(fine_c) << (big_c ? HI_SH : LO_SH);
    if (quo == '0)                       sda_c = '0;
    else if (quo <= DW'(SDA_BAND))       sda_c = SDA_W'(1);
    else if (quo <= DW'(2 * SDA_BAND))   sda_c = SDA_W'(2);
    else                                 sda_c = SDA_W'(SDA_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      c_clk    <= '0;
      c_tgt    <= '0;
      c_ns     <= '0;
      div_go   <= 1'b0;
      div_num  <= '0;
      div_den  <= '0;
      big_q    <= 1'b0;
      fine_q   <= '0;
      res_vld  <= 1'b0;
      res_err  <= 1'b0;
      res_big  <= 1'b0;
      res_fine <= '0;
      res_ach  <= '0;
      res_sda  <= '0;
      res_filt <= 1'b0;
    end else begin
      div_go  <= 1'b0;
      res_vld <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start) begin
          c_clk   <= clk_khz;
          c_tgt   <= (tgt_khz == '0) ? KHZ_W'(DEF_TGT) : tgt_khz;
          c_ns    <= dly_ns;
          div_num <= DW'(clk_khz);
          div_den <= (tgt_khz == '0) ? DW'(DEF_TGT) : DW'(tgt_khz);
          div_go  <= 1'b1;
          st_q    <= ST_RATIO;
        end
        ST_RATIO: if (div_done) begin
          big_q   <= big_c;
          fine_q  <= fine_c;
          div_num <= DW'(c_clk);
          div_den <= den_c;
          div_go  <= 1'b1;
          st_q    <= ST_RATE;
        end
        ST_RATE: if (div_done) begin
          res_ach <= quo[KHZ_W-1:0];
          res_err <= quo[KHZ_W-1:0] > c_tgt;
          div_num <= DW'(quo[KHZ_W-1:0]) * DW'(c_ns);
          div_den <= DW'(NS_SCALE);
          div_go  <= 1'b1;
          st_q    <= ST_SDA;
        end
        ST_SDA: if (div_done) begin
          res_sda  <= (c_ns == '0) ? '0 : sda_c;
          res_filt <= c_ns != '0;
          res_big  <= big_q;
          res_fine <= fine_q - 1'b1;
          res_vld  <= 1'b1;
          st_q     <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = st_q != ST_IDLE;
endmodule

// File: rtl/scl_tick_gen.sv
module scl_tick_gen
  import scl_cfg_pkg::*;
#(
  parameter int unsigned CNT_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              in_big,
  input  logic [FINE_W-1:0] in_fine,
  input  logic [SDA_W-1:0]  in_sda,
  input  logic              in_filt,
  output logic              big,
  output logic [FINE_W-1:0] fine,
  output logic [SDA_W-1:0]  sda,
  output logic              filt,
  output logic              tick
);
  logic              pend_q, s_big, s_filt;
  logic [FINE_W-1:0] s_fine;
  logic [SDA_W-1:0]  s_sda;
  logic [CNT_W-1:0]  cnt_q, period;
  logic              wrap;

  assign period = (CNT_W'(fine) + 1'b1) << (big ? HI_SH : LO_SH);
  assign wrap   = cnt_q == period - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      s_big  <= 1'b0;
      s_fine <= '0;
      s_sda  <= '0;
      s_filt <= 1'b0;
      big    <= 1'b0;
      fine   <= '0;
      sda    <= '0;
      filt   <= 1'b0;
      cnt_q  <= '0;
      tick   <= 1'b0;
    end else begin
      tick  <= wrap;
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap && pend_q) begin
        big    <= s_big;
        fine   <= s_fine;
        sda    <= s_sda;
        filt   <= s_filt;
        pend_q <= 1'b0;
      end
      if (load) begin
        pend_q <= 1'b1;
        s_big  <= in_big;
        s_fine <= in_fine;
        s_sda  <= in_sda;
        s_filt <= in_filt;
      end
    end
  end
endmodule

// File: rtl/scl_div_cfg.sv
module scl_div_cfg
  import scl_cfg_pkg::*;
#(
  parameter int unsigned KHZ_W = 20,
  parameter int unsigned NS_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [KHZ_W-1:0]  clk_khz,
  input  logic [KHZ_W-1:0]  tgt_khz,
  input  logic [NS_W-1:0]   dly_ns,
  output logic              busy,
  output logic              cfg_err,
  output logic [KHZ_W-1:0]  achieved_khz,
  output logic              coarse_sel,
  output logic [FINE_W-1:0] fine_field,
  output logic [SDA_W-1:0]  sda_dly,
  output logic              filt_en,
  output logic              tick
);
  localparam int unsigned CNT_W = $clog2((FINE_MAX << HI_SH) + 1);

  logic              r_vld, r_err, r_big, r_filt;
  logic [FINE_W-1:0] r_fine;
  logic [KHZ_W-1:0]  r_ach;
  logic [SDA_W-1:0]  r_sda;

  scl_cfg_calc #(.KHZ_W(KHZ_W), .NS_W(NS_W)) u_calc (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .clk_khz  (clk_khz),
    .tgt_khz  (tgt_khz),
    .dly_ns   (dly_ns),
    .busy     (busy),
    .res_vld  (r_vld),
    .res_err  (r_err),
    .res_big  (r_big),
    .res_fine (r_fine),
    .res_ach  (r_ach),
    .res_sda  (r_sda),
    .res_filt (r_filt)
  );

  scl_tick_gen #(.CNT_W(CNT_W)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .load    (r_vld && !r_err),
    .in_big  (r_big),
    .in_fine (r_fine),
    .in_sda  (r_sda),
    .in_filt (r_filt),
    .big     (coarse_sel),
    .fine    (fine_field),
    .sda     (sda_dly),
    .filt    (filt_en),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_err      <= 1'b0;
      achieved_khz <= '0;
    end else if (r_vld) begin
      cfg_err      <= r_err;
      achieved_khz <= r_ach;
    end
  end
endmodule

// File: rtl/scl_div_cfg_chk.sv
module scl_div_cfg_chk #(
  parameter int unsigned KHZ_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             tick,
  input logic             coarse_sel,
  input logic [4:0]       fine_field,
  input logic [1:0]       sda_dly,
  input logic             filt_en,
  input logic [KHZ_W-1:0] achieved_khz
);
  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R7

  AST_APPLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !$stable({coarse_sel, fine_field, sda_dly, filt_en}) |-> tick); // R8

  AST_FINE_CLAMP: assert property (@(posedge clk) disable iff (rst)
    fine_field <= 5'd16); // R3

  AST_FILT_WITH_DLY: assert property (@(posedge clk) disable iff (rst)
    (sda_dly != 2'd0) |-> filt_en); // R6

  AST_START_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> busy); // R9

  AST_RATE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(achieved_khz)); // R9
endmodule

bind scl_div_cfg scl_div_cfg_chk #(.KHZ_W(KHZ_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .busy         (busy),
  .tick         (tick),
  .coarse_sel   (coarse_sel),
  .fine_field   (fine_field),
  .sda_dly      (sda_dly),
  .filt_en      (filt_en),
  .achieved_khz (achieved_khz)
);

// File: tb/test_scl_div_cfg.sv
module test_scl_div_cfg;
  localparam int KHZ_W = 20;
  localparam int NS_W  = 20;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [KHZ_W-1:0] clk_khz = '0;
  logic [KHZ_W-1:0] tgt_khz = '0;
  logic [NS_W-1:0]  dly_ns = '0;
  logic             busy, cfg_err, coarse_sel, filt_en, tick;
  logic [KHZ_W-1:0] achieved_khz;
  logic [4:0]       fine_field;
  logic [1:0]       sda_dly;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // live setting as the bench expects it
  longint cur_big = 0, cur_field = 0, cur_sda = 0, cur_filt = 0;

  always #4 clk = ~clk;

  scl_div_cfg #(.KHZ_W(KHZ_W), .NS_W(NS_W)) i_scl_div_cfg (
    .clk (clk), .rst (rst), .start (start), .clk_khz (clk_khz),
    .tgt_khz (tgt_khz), .dly_ns (dly_ns), .busy (busy), .cfg_err (cfg_err),
    .achieved_khz (achieved_khz), .coarse_sel (coarse_sel),
    .fine_field (fine_field), .sda_dly (sda_dly), .filt_en (filt_en),
    .tick (tick)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(input longint exp_p, input string tag);
    longint n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < 20000);
    chk(n == exp_p, tag, n, exp_p);
  endtask

  task automatic run_cfg(input longint ck, input longint tg, input longint ns,
                         input bit meas, input bit mid_start);
    longint t, r, c, f, ach, q, e_sda, e_big, e_err, e_filt;
    bit ok8;
    t = (tg == 0) ? 100 : tg;
    r = ck / t;
    e_big = (r > 256) ? 1 : 0;
    c = e_big ? 512 : 16;
    f = (r + c - 1) / c;
    if (f < 1) f = 1;
    if (f > 17) f = 17;
    ach = ck / (f * c);
    e_err = (ach > t) ? 1 : 0;
    q = (ach * ns) / 1000000000;
    e_sda = (ns == 0 || q == 0) ? 0 : ((q + 4) / 5 > 3 ? 3 : (q + 4) / 5);
    e_filt = (ns != 0) ? 1 : 0;

    @(negedge clk);
    clk_khz = KHZ_W'(ck);
    tgt_khz = KHZ_W'(tg);
    dly_ns  = NS_W'(ns);
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9 busy after start", longint'(busy), 1);
    if (mid_start) begin
      repeat (5) @(negedge clk);
      clk_khz = KHZ_W'(ck + 777);
      tgt_khz = KHZ_W'(3);
      dly_ns  = NS_W'(0);
      start   = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R9 busy through ignored start", longint'(busy), 1);
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(achieved_khz == KHZ_W'(ach), tg == 0 ? "R1 R4 achieved rate (default target)" : "R4 achieved rate",
        longint'(achieved_khz), ach);
    chk(cfg_err == e_err[0], tg == 0 ? "R1 R5 error flag (default target)" : "R5 error flag",
        longint'(cfg_err), e_err);

    ok8 = 1;
    while (!tick) begin
      if (coarse_sel != cur_big[0] || fine_field != 5'(cur_field) ||
          sda_dly != 2'(cur_sda) || filt_en != cur_filt[0]) ok8 = 0;
      @(negedge clk);
    end
    chk(ok8, "R8 setting held until tick", longint'(ok8), 1);

    if (!e_err) begin
      cur_big = e_big; cur_field = f - 1; cur_sda = e_sda; cur_filt = e_filt;
    end
    chk(coarse_sel == cur_big[0], e_err ? "R5 coarse kept on error" : "R2 coarse select",
        longint'(coarse_sel), cur_big);
    chk(fine_field == 5'(cur_field), e_err ? "R5 fine kept on error" : "R3 fine field",
        longint'(fine_field), cur_field);
    chk(sda_dly == 2'(cur_sda), "R6 sda delay code", longint'(sda_dly), cur_sda);
    chk(filt_en == cur_filt[0], "R6 filter enable", longint'(filt_en), cur_filt);
    if (meas) measure((cur_field + 1) * (cur_big ? 512 : 16), "R7 tick period");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    longint cks[7] = '{0, 1000, 4000, 12000, 24000, 66000, 100000};
    longint tgs[5] = '{0, 100, 400, 1000, 3000};
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(busy == 0 && cfg_err == 0 && achieved_khz == 0, "R10 reset status", longint'(achieved_khz), 0);
    chk(coarse_sel == 0 && fine_field == 0 && sda_dly == 0 && filt_en == 0,
        "R10 reset setting", longint'(fine_field), 0);
    while (!tick) @(negedge clk);
    measure(16, "R10 reset tick period");

    // R2 R3 boundaries
    run_cfg(25600, 100, 0, 1, 0);   // ratio 256 -> 16, fine 16
    run_cfg(25700, 100, 0, 1, 0);   // ratio 257 -> 512, fine 1
    run_cfg(870500, 100, 0, 1, 0);  // ratio 8705 -> fine clamped to 17
    // R5 rejected configuration
    run_cfg(100000, 1, 5000, 1, 0);
    // R6 delay bands
    run_cfg(1000000, 62500, 0, 0, 0);
    run_cfg(1000000, 62500, 10, 0, 0);
    run_cfg(1000000, 62500, 16000, 0, 0);
    run_cfg(1000000, 62500, 96000, 0, 0);
    run_cfg(1000000, 62500, 700000, 1, 0);
    // R9 start during a run
    run_cfg(24000, 400, 1234, 1, 1);
    // sweep
    for (int i = 0; i < 7; i++)
      for (int j = 0; j < 5; j++)
        run_cfg(cks[i], tgs[j], ((i * 5 + j) * 30011) % 1000000, ((i + j) % 4) == 0, 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule